// File: doc/BRIEF.md
# Monochrome LCD Panel Scan Driver

This block scans a passive four-shade LCD panel that is 160 pixels wide and 144 lines tall. It reads each pixel's 2-bit shade from an external frame buffer through a synchronous read port. It then sends the shade out as two parallel bit-planes on a gated pixel clock, with a horizontal sync, a vertical sync, a line latch and a drive-polarity signal.

All timing comes from a clock enable ("tick") that is divided down from the system clock. One pixel takes two ticks: the clock is high in the first tick and low in the second. The panel samples the data on the falling edge.

The sequencer is one state machine with these states:

- `S_OFF`: display disabled.
- `S_VSYNC`: frame start, one tick.
- `S_HSYNC`: line start, one tick.
- `S_ACTIVE`: `2*H_PIX` ticks of pixel transfer.
- `S_LATCH`: one tick.
- `S_HBLANK`: `H_BLANK` ticks.
- `S_VBLANK`: `V_BLANK` ticks.

The named transitions are:

- **enable** (`S_OFF` to `S_VSYNC`)
- **frame-begin** (`S_VSYNC` to `S_HSYNC`)
- **line-begin** (`S_HSYNC` to `S_ACTIVE`)
- **line-end** (`S_ACTIVE` to `S_LATCH` after the last pixel)
- **latch-done** (`S_LATCH` to `S_HBLANK`)
- **next-line** (`S_HBLANK` to `S_HSYNC`)
- **frame-end** (`S_HBLANK` to `S_VBLANK` on the last line)
- **frame-wrap** (`S_VBLANK` to `S_VSYNC`)
- **disable** (any state to `S_OFF` when the enable input drops)

Top module: `lcd_scan_driver`

## Requirements
- R1: Pixel c of line r carries the frame-buffer value at address r*H_PIX+c. The buffer is a synchronous read port whose data follows the address by one clock. Pixels go out in ascending address order. `lcd_d0` carries shade bit 0 and `lcd_d1` carries shade bit 1, so d0/d1 = 0/0 is shade 0, 1/0 is shade 1, 0/1 is shade 2 and 1/1 is shade 3.
- R2: The data lines change only on the rising edge of `lcd_pclk` (or when the display is disabled), so they are stable at every falling edge.
- R3: `lcd_pclk` makes exactly H_PIX high pulses per line. It is low while hsync, vsync or latch is high, and whenever no line is being transferred.
- R4: One `lcd_hsync` pulse precedes each line's pixels, and each frame has V_LINES hsync pulses.
- R5: One `lcd_vsync` pulse starts every frame. After the display is enabled, vsync comes before any hsync.
- R6: One `lcd_latch` pulse follows each line. It rises after the line's last pixel-clock falling edge, once H_PIX pixels have been clocked.
- R7: `lcd_alt` inverts exactly once per frame, at the rising edge of vsync.
- R8: In reset, and within one clock after `en` goes low, `lcd_disp_en` is low. While it is low, pclk, hsync, vsync, latch and both data lines are low.
- R9: Consecutive hsync rises within a frame are (2*H_PIX+H_BLANK+2)*TICK_DIV clocks apart. Consecutive vsync rises are (1+V_LINES*(2*H_PIX+H_BLANK+2)+V_BLANK)*TICK_DIV clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Display enable request |
| fb_addr | output | clog2(H_PIX*V_LINES) | Frame-buffer read address |
| fb_shade | input | 2 | Shade returned one clock after the address |
| lcd_pclk | output | 1 | Gated pixel shift clock |
| lcd_d0 | output | 1 | Shade bit 0 |
| lcd_d1 | output | 1 | Shade bit 1 |
| lcd_hsync | output | 1 | Line-start pulse |
| lcd_vsync | output | 1 | Frame-start pulse |
| lcd_latch | output | 1 | Line latch pulse, panel acts on its fall |
| lcd_alt | output | 1 | Drive polarity, inverted each frame |
| lcd_disp_en | output | 1 | Display enable to the panel |

## Verification
The hardest case to reach from the ports is a disable that lands between the end of a frame's last line and the next vsync, followed by a re-enable. The restart must begin with vsync and still toggle the polarity correctly. The bench gets there by draining the expected-pixel queue of a whole frame, waiting a few clocks into the latch or blanking period, dropping `en`, and then re-enabling with a new shade pattern. The shade patterns are chosen so that a swap of the data lines or an off-by-one address shows up in the pixel comparison.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

    typedef enum logic [2:0] {
        S_OFF    = 3'd0,
        S_VSYNC  = 3'd1,
        S_HSYNC  = 3'd2,
        S_ACTIVE = 3'd3,
        S_LATCH  = 3'd4,
        S_HBLANK = 3'd5,
        S_VBLANK = 3'd6
    } scan_state_t;

endpackage

// File: rtl/lcdscan_tick.sv
module lcdscan_tick #(
    parameter int TICK_DIV = 2,
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    generate
        if (TICK_DIV > 1) begin : g_div
            logic [TW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)
                    cnt <= '0;
                else if (cnt == TW'(TICK_DIV - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + TW'(1);
            end
            assign tick = (cnt == TW'(TICK_DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/lcdscan_ctrl.sv
module lcdscan_ctrl
    import lcdscan_pkg::*;
#(
    parameter int H_PIX   = 160,
    parameter int V_LINES = 144,
    parameter int H_BLANK = 8,
    parameter int V_BLANK = 16,
    localparam int AW = $clog2(H_PIX * V_LINES),
    localparam int CW = $clog2(H_PIX + 1),
    localparam int RW = $clog2(V_LINES + 1),
    localparam int BMAX = (H_BLANK > V_BLANK) ? H_BLANK : V_BLANK,
    localparam int BW = $clog2(BMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    output scan_state_t   n_st,
    output logic          n_ph,
    output logic [AW-1:0] fb_addr
);

    scan_state_t   st;
    logic          ph;
    logic [CW-1:0] col, n_col;
    logic [RW-1:0] row, n_row;
    logic [BW-1:0] bc, n_bc;
    logic [AW-1:0] idx, n_idx;

    // Next-state and next-counter decode
    always_comb begin
        n_st  = st;
        n_ph  = ph;
        n_col = col;
        n_row = row;
        n_bc  = bc;
        n_idx = idx;
        unique case (st)
            S_OFF: begin                    // enable
                n_st  = S_VSYNC;
                n_row = '0;
                n_col = '0;
                n_idx = '0;
            end
            S_VSYNC: begin                  // frame-begin
                n_st  = S_HSYNC;
                n_row = '0;
                n_idx = '0;
            end
            S_HSYNC: begin                  // line-begin
                n_st  = S_ACTIVE;
                n_col = '0;
                n_ph  = 1'b0;
            end
            S_ACTIVE: begin
                if (!ph) begin
                    n_ph = 1'b1;
                end else begin
                    n_ph  = 1'b0;
                    n_idx = idx + AW'(1);
                    if (col == CW'(H_PIX - 1))
                        n_st = S_LATCH;     // line-end
                    else
                        n_col = col + CW'(1);
                end
            end
            S_LATCH: begin                  // latch-done
                n_st = S_HBLANK;
                n_bc = '0;
            end
            S_HBLANK: begin
                if (bc == BW'(H_BLANK - 1)) begin
                    n_bc = '0;
                    if (row == RW'(V_LINES - 1)) begin
                        n_st = S_VBLANK;    // frame-end
                    end else begin
                        n_st  = S_HSYNC;    // next-line
                        n_row = row + RW'(1);
                    end
                end else begin
                    n_bc = bc + BW'(1);
                end
            end
            S_VBLANK: begin
                if (bc == BW'(V_BLANK - 1)) begin
                    n_st = S_VSYNC;         // frame-wrap
                    n_bc = '0;
                end else begin
                    n_bc = bc + BW'(1);
                end
            end
            default: n_st = S_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst || !en) begin               // disable
            st  <= S_OFF;
            ph  <= 1'b0;
            col <= '0;
            row <= '0;
            bc  <= '0;
            idx <= '0;
        end else if (tick) begin
            st  <= n_st;
            ph  <= n_ph;
            col <= n_col;
            row <= n_row;
            bc  <= n_bc;
            idx <= n_idx;
        end
    end

    // Address of the pixel loaded at the coming tick; it is held for the whole tick period.
    assign fb_addr = n_idx;

    // R1: the address feeding a pixel load has been steady for at least one clock
    a_r1_addr_ahead: assert property (@(posedge clk) disable iff (rst)
        (tick && en && n_st == S_ACTIVE && !n_ph) |-> $stable(fb_addr));

endmodule

// File: rtl/lcdscan_drive.sv
module lcdscan_drive
    import lcdscan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        tick,
    input  scan_state_t n_st,
    input  logic        n_ph,
    input  logic [1:0]  fb_shade,
    output logic        lcd_pclk,
    output logic        lcd_d0,
    output logic        lcd_d1,
    output logic        lcd_hsync,
    output logic        lcd_vsync,
    output logic        lcd_latch,
    output logic        lcd_alt,
    output logic        lcd_disp_en
);

    logic load_px;
    assign load_px = (n_st == S_ACTIVE) && !n_ph;

    // Output register: every panel line is a flop updated on the tick
    always_ff @(posedge clk) begin
        if (rst) begin
            lcd_pclk    <= 1'b0;
            lcd_d0      <= 1'b0;
            lcd_d1      <= 1'b0;
            lcd_hsync   <= 1'b0;
            lcd_vsync   <= 1'b0;
            lcd_latch   <= 1'b0;
            lcd_alt     <= 1'b0;
            lcd_disp_en <= 1'b0;
        end else begin
            lcd_disp_en <= en;
            if (!en) begin
                lcd_pclk  <= 1'b0;
                lcd_d0    <= 1'b0;
                lcd_d1    <= 1'b0;
                lcd_hsync <= 1'b0;
                lcd_vsync <= 1'b0;
                lcd_latch <= 1'b0;
            end else if (tick) begin
                lcd_pclk  <= load_px;
                lcd_hsync <= (n_st == S_HSYNC);
                lcd_vsync <= (n_st == S_VSYNC);
                lcd_latch <= (n_st == S_LATCH);
                if (load_px) begin
                    lcd_d0 <= fb_shade[0];
                    lcd_d1 <= fb_shade[1];
                end
                if (n_st == S_VSYNC)
                    lcd_alt <= ~lcd_alt;
            end
        end
    end

    // R2: data moves only with a rising pixel clock or on disable
    a_r2_data_steady: assert property (@(posedge clk) disable iff (rst)
        !$stable({lcd_d1, lcd_d0}) |-> ($rose(lcd_pclk) || !lcd_disp_en));

    // R3: no pixel clock during sync or latch pulses
    a_r3_pclk_quiet: assert property (@(posedge clk) disable iff (rst)
        lcd_pclk |-> !(lcd_hsync || lcd_vsync || lcd_latch));

    // R6: latch rises only after the pixel clock has fallen
    a_r6_latch_after_px: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_latch) |-> (!lcd_pclk && !$past(lcd_pclk)));

    // R7: polarity flips only together with the frame-start pulse
    a_r7_alt_at_frame: assert property (@(posedge clk) disable iff (rst)
        !$stable(lcd_alt) |-> $rose(lcd_vsync));

    // R8: disabled panel sees idle lines
    a_r8_off_idle: assert property (@(posedge clk) disable iff (rst)
        !lcd_disp_en |-> !(lcd_pclk || lcd_hsync || lcd_vsync || lcd_latch || lcd_d0 || lcd_d1));

endmodule

// File: rtl/lcd_scan_driver.sv
module lcd_scan_driver
    import lcdscan_pkg::*;
#(
    parameter int H_PIX    = 160,
    parameter int V_LINES  = 144,
    parameter int TICK_DIV = 2,
    parameter int H_BLANK  = 8,
    parameter int V_BLANK  = 16,
    localparam int AW = $clog2(H_PIX * V_LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [AW-1:0] fb_addr,
    input  logic [1:0]    fb_shade,
    output logic          lcd_pclk,
    output logic          lcd_d0,
    output logic          lcd_d1,
    output logic          lcd_hsync,
    output logic          lcd_vsync,
    output logic          lcd_latch,
    output logic          lcd_alt,
    output logic          lcd_disp_en
);

    logic        tick;
    scan_state_t n_st;
    logic        n_ph;

    lcdscan_tick #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    lcdscan_ctrl #(
        .H_PIX   (H_PIX),
        .V_LINES (V_LINES),
        .H_BLANK (H_BLANK),
        .V_BLANK (V_BLANK)
    ) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .tick    (tick),
        .n_st    (n_st),
        .n_ph    (n_ph),
        .fb_addr (fb_addr)
    );

    lcdscan_drive i_drive (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .tick        (tick),
        .n_st        (n_st),
        .n_ph        (n_ph),
        .fb_shade    (fb_shade),
        .lcd_pclk    (lcd_pclk),
        .lcd_d0      (lcd_d0),
        .lcd_d1      (lcd_d1),
        .lcd_hsync   (lcd_hsync),
        .lcd_vsync   (lcd_vsync),
        .lcd_latch   (lcd_latch),
        .lcd_alt     (lcd_alt),
        .lcd_disp_en (lcd_disp_en)
    );

endmodule

// File: tb/test_lcd_scan_driver.sv
module test_lcd_scan_driver;

    localparam int CLK_PERIOD = 10;
    localparam int H   = 8;
    localparam int V   = 4;
    localparam int DIV = 2;
    localparam int HB  = 3;
    localparam int VB  = 5;
    localparam int AW  = $clog2(H * V);
    localparam int LINE_CYC  = (2 * H + HB + 2) * DIV;
    localparam int FRAME_CYC = (1 + V * (2 * H + HB + 2) + VB) * DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [AW-1:0] fb_addr;
    logic [1:0]    fb_shade = 2'd0;
    logic lcd_pclk, lcd_d0, lcd_d1, lcd_hsync, lcd_vsync, lcd_latch, lcd_alt, lcd_disp_en;

    int checks = 0;
    int fails  = 0;
    int pat    = 0;
    int q[$];
    bit done = 0;
    bit need_vs = 0;
    int hs_since_en = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_scan_driver #(
        .H_PIX(H), .V_LINES(V), .TICK_DIV(DIV), .H_BLANK(HB), .V_BLANK(VB)
    ) i_lcd_scan_driver (
        .clk(clk), .rst(rst), .en(en), .fb_addr(fb_addr), .fb_shade(fb_shade),
        .lcd_pclk(lcd_pclk), .lcd_d0(lcd_d0), .lcd_d1(lcd_d1),
        .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_latch(lcd_latch),
        .lcd_alt(lcd_alt), .lcd_disp_en(lcd_disp_en)
    );

    function automatic logic [1:0] shade_of(int p, int a);
        case (p)
            0:       return 2'd3;
            1:       return a[1:0];
            default: return 2'(a * 5 + (a >> 3) + 1);
        endcase
    endfunction

    // Frame-buffer model: one-clock synchronous read
    always @(posedge clk) fb_shade <= shade_of(pat, int'(fb_addr));

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard driver: expected pixels in scan order
    task automatic push_frames(int n, int p);
        for (int f = 0; f < n; f++)
            for (int a = 0; a < H * V; a++)
                q.push_back((a << 2) | int'(shade_of(p, a)));
    endtask

    task automatic check_idle(string req);
        check(!lcd_disp_en && !lcd_pclk && !lcd_hsync && !lcd_vsync && !lcd_latch
              && !lcd_d0 && !lcd_d1, req,
              int'({lcd_disp_en, lcd_pclk, lcd_hsync, lcd_vsync, lcd_latch, lcd_d1, lcd_d0}), 0);
    endtask

    task automatic run(int n, int p);
        @(negedge clk);
        pat = p;                          // changed while disabled
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i == 11) check_idle("R8 idle while disabled");
        end
        push_frames(n, p);
        need_vs = 1;
        hs_since_en = 0;
        en = 1'b1;
        wait (q.size() == 0);
        repeat (4) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check_idle("R8 idle one clock after disable");
    endtask

    // Monitor
    bit prev_pclk = 0, prev_hs = 0, prev_vs = 0, prev_lat = 0, prev_alt = 0;
    bit seen_vs = 0, in_line = 0, vs_valid = 0;
    int cyc = 0, last_hs = 0, last_vs = 0, hs_cnt = 0, pix_in_line = 0;
    logic [1:0] data_at_rise = 2'd0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (!prev_pclk && lcd_pclk) begin
                data_at_rise = {lcd_d1, lcd_d0};
                check(in_line && !lcd_hsync && !lcd_vsync && !lcd_latch,
                      "R3 pclk only inside a line", int'(in_line), 1);
            end
            if (prev_pclk && !lcd_pclk) begin
                check({lcd_d1, lcd_d0} == data_at_rise, "R2 data stable at falling edge",
                      int'({lcd_d1, lcd_d0}), int'(data_at_rise));
                if (q.size() == 0) begin
                    check(0, "R1 unexpected pixel", int'({lcd_d1, lcd_d0}), -1);
                end else begin
                    int e;
                    e = q.pop_front();
                    check({lcd_d1, lcd_d0} == 2'(e), "R1 pixel shade",
                          int'({lcd_d1, lcd_d0}), e & 3);
                end
                pix_in_line++;
            end
            if (!prev_lat && lcd_latch) begin
                check(pix_in_line == H && in_line, "R6 latch after full line", pix_in_line, H);
                check(pix_in_line == H, "R3 pixel clocks per line", pix_in_line, H);
                pix_in_line = 0;
                in_line = 0;
            end
            if (!prev_hs && lcd_hsync) begin
                if (need_vs)
                    check(0, "R5 hsync before vsync after enable", hs_since_en, 0);
                if (hs_cnt > 0)
                    check(cyc - last_hs == LINE_CYC, "R9 line period", cyc - last_hs, LINE_CYC);
                check(!in_line, "R4 hsync precedes line", int'(in_line), 0);
                last_hs = cyc;
                hs_cnt++;
                hs_since_en++;
                in_line = 1;
                pix_in_line = 0;
            end
            if (!prev_vs && lcd_vsync) begin
                if (need_vs)
                    check(hs_since_en == 0, "R5 vsync first after enable", hs_since_en, 0);
                if (seen_vs) begin
                    check(hs_cnt == V, "R4 hsync count per frame", hs_cnt, V);
                    check(lcd_alt != prev_alt, "R7 polarity flip", int'(lcd_alt), int'(!prev_alt));
                end
                if (vs_valid && !need_vs)
                    check(cyc - last_vs == FRAME_CYC, "R9 frame period", cyc - last_vs, FRAME_CYC);
                vs_valid = 1;
                last_vs = cyc;
                seen_vs = 1;
                prev_alt = lcd_alt;
                hs_cnt = 0;
                need_vs = 0;
            end
            if (!en) vs_valid = 0;
            prev_pclk = lcd_pclk;
            prev_hs   = lcd_hsync;
            prev_vs   = lcd_vsync;
            prev_lat  = lcd_latch;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check_idle("R8 reset state");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R8 after reset, disabled");
        run(2, 1);
        run(2, 0);
        run(2, 2);
        check(q.size() == 0, "R1 all pixels delivered", q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", q.size(), 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule